// File: doc/BRIEF.md
# Serial NOR Flash Command Front-End

This block is the slave side of a serial flash model. It sits behind a four-wire SPI port (serial clock, active-low select, data in, data out) and accepts either SPI mode 0 or mode 3. Every frame opens with an 8-bit opcode. Some opcodes then take a 24-bit address, and some take data bytes. All fields are shifted most significant bit first on rising clock edges. Read-type commands drive response bytes back on the falling edges. Outside a read phase the data-out pin is released, which is signalled on a separate output-enable pin.

The storage behind the port is a small byte-wide register array that stands in for flash cells. Program and erase are self-timed. They are launched when select returns high after a correctly framed command. While they run, a busy flag is set for a parameterised number of system clocks, and it can be polled through the status read. All SPI inputs are synchronised into the system clock domain and their edges are detected there. The serial clock must therefore be several times slower than the system clock.

Top module: `sflash_front`

## Requirements
- R1: Both SPI mode 0 (clock idles low) and mode 3 (clock idles high) are accepted. Input bits are captured on rising serial-clock edges, most significant bit first. Output bits change on falling edges, most significant bit first.
- R2: `spi_miso_oe` is 0 whenever select is high, and whenever the current frame is not in the response phase of a read-type command.
- R3: Opcode 0x05 returns the status byte. Bit 0 is the busy flag, bit 1 is the write-enable latch, and bits 7:2 are the user bits. The byte repeats for as long as select stays low. The command is accepted while a self-timed operation runs.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Either takes effect only when select rises after exactly one complete byte.
- R5: Opcode 0x9F returns the manufacturer byte, then the two device bytes with the high byte first. The three-byte sequence then repeats.
- R6: Opcode 0x03 takes a 24-bit address and then streams array bytes. The address increments after each byte and wraps from the top of the array to 0; address bits above the array size are ignored.
- R7: Opcode 0x0B behaves like 0x03, except that one dummy byte follows the address before data is driven.
- R8: Opcode 0x02 takes an address and then data bytes. The data index wraps inside its PAGE_BYTES-aligned page. When select rises with the latch set and at least one full data byte received, each buffered byte is ANDed into the array. A frame without the latch changes nothing.
- R9: Opcodes 0x60 and 0xC7 each set every array byte to 0xFF. The operation starts when select rises after a lone opcode byte with the latch set. The busy flag stays 1 for max(BUSY_CYCLES, MEM_BYTES) clocks.
- R10: Opcode 0x01 followed by one data byte copies data bits 7:2 into the user status bits when select rises with the latch set. It also runs a busy period of the same length as R9.
- R11: Starting any self-timed operation clears the write-enable latch. While busy, every opcode other than 0x05 is ignored for the rest of its frame.
- R12: An opcode that is not listed puts the port in standby. It ignores all bits and drives nothing until select rises.
- R13: Opcode 0xB9 enters deep power-down when select rises. In power-down, every opcode except 0xAB is ignored. Opcode 0xAB returns the device low byte after three dummy bytes, and it leaves power-down when select rises.
- R14: Opcodes 0x90 and 0xEF take a 24-bit address. They then alternate the manufacturer byte and the device low byte, starting with the manufacturer byte when address bit 0 is 0 and with the device byte when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | High while `spi_miso` must be driven |

## Verification
The bound checker watches the following on every cycle:
- the output enable drops after select goes high;
- a busy period, once started, is not cut short;
- the write-enable latch is clear whenever busy rises;
- no operation is launched while another is running, and at most one launch is requested at a time;
- the standby state never drives the output;
- power-down admits only the release command.

Other behaviour depends on data values and is shown only by the bench scenarios:
- identification bytes and their ordering;
- address increment and wrap-around;
- the fast-read dummy byte;
- the AND effect of programming and the wrap of data inside a page;
- user status bits written by the status write;
- commands that are ignored while busy or powered down.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [3:0] {
    C_NONE, C_WREN, C_WRDI, C_RDID, C_RDSR, C_WRSR, C_READ,
    C_FAST, C_PP, C_CE, C_DP, C_RES, C_REMS, C_IGN
  } cmd_e;

  typedef enum logic [1:0] {W_IDLE, W_PROG, W_ERASE, W_HOLD} work_e;

  function automatic cmd_e decode(input logic [7:0] op);
    case (op)
      8'h06:        return C_WREN;
      8'h04:        return C_WRDI;
      8'h9F:        return C_RDID;
      8'h05:        return C_RDSR;
      8'h01:        return C_WRSR;
      8'h03:        return C_READ;
      8'h0B:        return C_FAST;
      8'h02:        return C_PP;
      8'h60, 8'hC7: return C_CE;
      8'hB9:        return C_DP;
      8'hAB:        return C_RES;
      8'h90, 8'hEF: return C_REMS;
      default:      return C_IGN;
    endcase
  endfunction

endpackage

// File: rtl/sfc_edge.sv
module sfc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic sel,
  output logic mosi_s
);
  // two-stage synchronisers: {cs_n, sck, mosi}
  logic [2:0] s1_q, s2_q;
  logic       sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 3'b100;
      s2_q  <= 3'b100;
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      s1_q  <= {cs_n_i, sck_i, mosi_i};
      s2_q  <= s1_q;
      sck_q <= s2_q[1];
      cs_q  <= s2_q[2];
    end
  end

  assign sck_rise = s2_q[1] & ~sck_q;
  assign sck_fall = ~s2_q[1] & sck_q;
  assign cs_rise  = s2_q[2] & ~cs_q;
  assign sel      = ~s2_q[2];
  assign mosi_s   = s2_q[0];
endmodule

// File: rtl/sfc_tx.sv
module sfc_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       load,
  input  logic       shift,
  input  logic [7:0] din,
  output logic       miso,
  output logic       oe
);
  logic [7:0] sh_q, sh_d;
  logic       act_q, act_d;

  always_comb begin
    sh_d  = sh_q;
    act_d = act_q;
    if (!sel) begin
      act_d = 1'b0;
    end else if (load) begin
      sh_d  = din;
      act_d = 1'b1;
    end else if (shift) begin
      sh_d = {sh_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= 8'h00;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      act_q <= act_d;
    end
  end

  assign miso = sh_q[7];
  assign oe   = act_q;
endmodule

// File: rtl/sfc_array.sv
module sfc_array #(
  parameter int MEM_BYTES   = 256,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 300,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_prog,
  input  logic                       start_erase,
  input  logic                       start_hold,
  input  logic [AW-PW-1:0]           page_base,
  input  logic [PAGE_BYTES-1:0][7:0] pdata,
  input  logic [PAGE_BYTES-1:0]      pvalid,
  input  logic [AW-1:0]              rd_addr,
  output logic [7:0]                 rd_data,
  output logic                       busy
);
  import sfc_pkg::*;

  localparam int BUSY_LEN = (BUSY_CYCLES > MEM_BYTES) ? BUSY_CYCLES : MEM_BYTES;
  localparam int CW       = $clog2(BUSY_LEN + 1);
  localparam logic [CW-1:0] LAST_C = CW'(BUSY_LEN - 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(MEM_BYTES);
  localparam logic [CW-1:0] PAGE_C = CW'(PAGE_BYTES);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [7:0]       mem [MEM_BYTES];
  work_e            kind_q, kind_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [AW-PW-1:0] base_q, base_d;
  logic [AW-1:0]    widx, pidx_full;
  logic [PW-1:0]    pidx;

  always_comb begin
    kind_d = kind_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    if (start_prog || start_erase || start_hold) begin
      kind_d = start_prog ? W_PROG : (start_erase ? W_ERASE : W_HOLD);
      cnt_d  = '0;
      base_d = page_base;
    end else if (kind_q != W_IDLE) begin
      if (cnt_q == LAST_C) kind_d = W_IDLE;
      else                 cnt_d  = cnt_q + ONE_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= W_IDLE;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
    end
  end

  assign widx      = cnt_q[AW-1:0];
  assign pidx      = cnt_q[PW-1:0];
  assign pidx_full = {base_q, pidx};

  // array cells carry no reset, as flash contents would not
  always_ff @(posedge clk) begin
    if (kind_q == W_ERASE && cnt_q < DEPTH_C)
      mem[widx] <= 8'hFF;
    else if (kind_q == W_PROG && cnt_q < PAGE_C && pvalid[pidx])
      mem[pidx_full] <= mem[pidx_full] & pdata[pidx];
  end

  assign rd_data = mem[rd_addr];
  assign busy    = (kind_q != W_IDLE);
endmodule

// File: rtl/sflash_front.sv
module sflash_front #(
  parameter int          MEM_BYTES   = 256,
  parameter int          PAGE_BYTES  = 16,
  parameter int          BUSY_CYCLES = 300,
  parameter logic [7:0]  MFR_ID      = 8'h5A,
  parameter logic [15:0] DEV_ID      = 16'h3117
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  import sfc_pkg::*;

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [PW-1:0] ONE_P = PW'(1);

  logic sck_rise, sck_fall, cs_rise, sel, mosi_s;
  logic busy;
  logic [7:0] rd_data;

  cmd_e                      cmd_q, cmd_d, dec, adm;
  logic [2:0]                bitcnt_q, bitcnt_d;
  logic [3:0]                bytecnt_q, bytecnt_d;
  logic [6:0]                sh_q, sh_d;
  logic [AW-1:0]             addr_q, addr_d;
  logic [5:0]                wrsr_q, wrsr_d, sr_user_q, sr_user_d;
  logic [PW-1:0]             pidx_q, pidx_d;
  logic [PAGE_BYTES-1:0]     pvalid_q, pvalid_d;
  logic [PAGE_BYTES-1:0][7:0] pbuf_q, pbuf_d;
  logic [1:0]                obyte_q, obyte_d;
  logic                      wel_q, wel_d, dp_q, dp_d;
  logic [7:0]                byte_in, status, tx_byte;
  logic                      tx_load, out_phase;
  logic                      start_prog, start_erase, start_wrsr;

  sfc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise), .sel(sel), .mosi_s(mosi_s)
  );

  assign byte_in = {sh_q, mosi_s};
  assign status  = {sr_user_q, wel_q, busy};
  assign dec     = decode(byte_in);

  always_comb begin
    if (dp_q)                       adm = (dec == C_RES) ? C_RES : C_IGN;
    else if (busy && dec != C_RDSR) adm = C_IGN;
    else                            adm = dec;
  end

  always_comb begin
    case (cmd_q)
      C_RDSR, C_RDID:         out_phase = (bytecnt_q >= 4'd1);
      C_READ, C_REMS, C_RES:  out_phase = (bytecnt_q >= 4'd4);
      C_FAST:                 out_phase = (bytecnt_q >= 4'd5);
      default:                out_phase = 1'b0;
    endcase
  end

  // next-state: frame decode, response selection and commit on select rise
  always_comb begin
    cmd_d     = cmd_q;
    bitcnt_d  = bitcnt_q;
    bytecnt_d = bytecnt_q;
    sh_d      = sh_q;
    addr_d    = addr_q;
    wrsr_d    = wrsr_q;
    sr_user_d = sr_user_q;
    pidx_d    = pidx_q;
    pvalid_d  = pvalid_q;
    pbuf_d    = pbuf_q;
    obyte_d   = obyte_q;
    wel_d     = wel_q;
    dp_d      = dp_q;
    tx_load   = 1'b0;
    tx_byte   = 8'h00;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    start_wrsr  = 1'b0;

    if (!sel) begin
      cmd_d     = C_NONE;
      bitcnt_d  = 3'd0;
      bytecnt_d = 4'd0;
      obyte_d   = 2'd0;
    end else begin
      if (sck_rise && cmd_q != C_IGN) begin
        sh_d     = {sh_q[5:0], mosi_s};
        bitcnt_d = bitcnt_q + 3'd1;
        if (bitcnt_q == 3'd7) begin
          if (bytecnt_q != 4'hF) bytecnt_d = bytecnt_q + 4'd1;
          if (bytecnt_q == 4'd0) begin
            cmd_d = adm;
            if (adm == C_PP) pvalid_d = '0;
          end else begin
            case (cmd_q)
              C_READ, C_FAST, C_REMS, C_PP: begin
                if (bytecnt_q <= 4'd3) begin
                  for (int j = 0; j < AW; j++)
                    if (bytecnt_q == 4'(3 - j / 8)) addr_d[j] = byte_in[j % 8];
                  if (cmd_q == C_PP && bytecnt_q == 4'd3) pidx_d = byte_in[PW-1:0];
                end else if (cmd_q == C_PP) begin
                  pbuf_d[pidx_q]   = byte_in;
                  pvalid_d[pidx_q] = 1'b1;
                  pidx_d           = pidx_q + ONE_P;
                end
              end
              C_WRSR: if (bytecnt_q == 4'd1) wrsr_d = byte_in[7:2];
              default: ;
            endcase
          end
        end
      end
      if (sck_fall && bitcnt_q == 3'd0 && out_phase) begin
        tx_load = 1'b1;
        case (cmd_q)
          C_RDSR: tx_byte = status;
          C_RDID: begin
            tx_byte = (obyte_q == 2'd0) ? MFR_ID : ((obyte_q == 2'd1) ? DEV_ID[15:8] : DEV_ID[7:0]);
            obyte_d = (obyte_q == 2'd2) ? 2'd0 : obyte_q + 2'd1;
          end
          C_READ, C_FAST: begin
            tx_byte = rd_data;
            addr_d  = addr_q + ONE_A;
          end
          C_REMS: begin
            tx_byte = (obyte_q[0] ^ addr_q[0]) ? DEV_ID[7:0] : MFR_ID;
            obyte_d = obyte_q + 2'd1;
          end
          default: tx_byte = DEV_ID[7:0];
        endcase
      end
    end

    if (cs_rise && bitcnt_q == 3'd0) begin
      case (cmd_q)
        C_WREN: if (bytecnt_q == 4'd1) wel_d = 1'b1;
        C_WRDI: if (bytecnt_q == 4'd1) wel_d = 1'b0;
        C_WRSR: if (bytecnt_q == 4'd2 && wel_q) begin
          start_wrsr = 1'b1;
          wel_d      = 1'b0;
          sr_user_d  = wrsr_q;
        end
        C_PP: if (bytecnt_q >= 4'd5 && wel_q) begin
          start_prog = 1'b1;
          wel_d      = 1'b0;
        end
        C_CE: if (bytecnt_q == 4'd1 && wel_q) begin
          start_erase = 1'b1;
          wel_d       = 1'b0;
        end
        C_DP:  if (bytecnt_q == 4'd1) dp_d = 1'b1;
        C_RES: dp_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= C_NONE;
      bitcnt_q  <= 3'd0;
      bytecnt_q <= 4'd0;
      sh_q      <= 7'd0;
      addr_q    <= '0;
      wrsr_q    <= 6'd0;
      sr_user_q <= 6'd0;
      pidx_q    <= '0;
      pvalid_q  <= '0;
      obyte_q   <= 2'd0;
      wel_q     <= 1'b0;
      dp_q      <= 1'b0;
    end else begin
      cmd_q     <= cmd_d;
      bitcnt_q  <= bitcnt_d;
      bytecnt_q <= bytecnt_d;
      sh_q      <= sh_d;
      addr_q    <= addr_d;
      wrsr_q    <= wrsr_d;
      sr_user_q <= sr_user_d;
      pidx_q    <= pidx_d;
      pvalid_q  <= pvalid_d;
      obyte_q   <= obyte_d;
      wel_q     <= wel_d;
      dp_q      <= dp_d;
    end
  end

  // page data is qualified by pvalid_q and needs no reset
  always_ff @(posedge clk) begin
    pbuf_q <= pbuf_d;
  end

  sfc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .sel(sel), .load(tx_load), .shift(sck_fall),
    .din(tx_byte), .miso(spi_miso), .oe(spi_miso_oe)
  );

  sfc_array #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .start_prog(start_prog), .start_erase(start_erase), .start_hold(start_wrsr),
    .page_base(addr_q[AW-1:PW]), .pdata(pbuf_q), .pvalid(pvalid_q),
    .rd_addr(addr_q), .rd_data(rd_data), .busy(busy)
  );
endmodule

// File: rtl/sflash_front_chk.sv
module sflash_front_chk (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          miso_oe,
  input logic          busy,
  input logic          wel,
  input logic          dp,
  input sfc_pkg::cmd_e cmd,
  input logic          start_prog,
  input logic          start_erase,
  input logic          start_wrsr
);
  import sfc_pkg::*;

  // R2: output released one cycle after deselect
  p_oe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso_oe);

  // R9: a busy period is never a single cycle
  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  // R11: latch is clear when busy begins
  p_wel_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wel);

  // R11: no launch while an operation runs
  p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase || start_wrsr) |-> !busy);

  // R8: at most one launch request per cycle
  p_one_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_prog, start_erase, start_wrsr}));

  // R12: standby never drives the output
  p_ign_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_IGN) |-> !miso_oe);

  // R13: power-down admits only the release command
  p_dp_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && cmd != C_NONE) |-> (cmd == C_RES || cmd == C_IGN));
endmodule

bind sflash_front sflash_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .miso_oe(spi_miso_oe), .busy(busy),
  .wel(wel_q), .dp(dp_q), .cmd(cmd_q), .start_prog(start_prog),
  .start_erase(start_erase), .start_wrsr(start_wrsr)
);

// File: tb/sflash_front_tb.sv
module sflash_front_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sck, cs_n, mosi;
  logic miso, oe;

  sflash_front #(.BUSY_CYCLES(2000)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(oe)
  );

  int   n_chk = 0;
  int   n_fail = 0;
  bit   mode3 = 1'b0;
  bit   oe_seen;
  bit   finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rx_last;
  logic       rx_oe;
  event       rx_ev;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    sck = mode3;
    wait_clk(4);
    cs_n = 1'b0;
    oe_seen = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_high();
    sck = mode3;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sck  = 1'b0;
      mosi = tx[i];
      wait_clk(HALF);
      rx[i]   = miso;
      oe_all  = oe_all & oe;
      oe_seen = oe_seen | oe;
      sck = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r;
    logic o;
    xfer(tx, r, o);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send(a[23:16]);
    send(a[15:8]);
    send(a[7:0]);
  endtask

  // driver side of the scoreboard
  task automatic sb_read(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    xfer(8'h00, rx_last, rx_oe);
    ->rx_ev;
    wait_clk(1);
  endtask

  // monitor side of the scoreboard
  always @(rx_ev) begin : monitor
    logic [7:0] e;
    string t;
    if (exp_q.size() == 0) begin
      check(1'b0, "scoreboard underflow", {8'h0, rx_last}, 16'h0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rx_oe === 1'b1 && rx_last === e, t, {7'h0, rx_oe, rx_last}, {8'h01, e});
    end
  end

  task automatic op_frame(input logic [7:0] op);
    cs_low();
    send(op);
    cs_high();
  endtask

  task automatic status_expect(input logic [7:0] exp, input string tag);
    cs_low();
    send(8'h05);
    sb_read(exp, tag);
    cs_high();
  endtask

  task automatic wait_ready();
    logic [7:0] r;
    logic o;
    for (int k = 0; k < 60; k++) begin
      cs_low();
      send(8'h05);
      xfer(8'h00, r, o);
      cs_high();
      if (r[0] === 1'b0) return;
    end
    check(1'b0, "R9 busy never cleared", 16'h1, 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 16'h0, 16'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check(oe === 1'b0, "R2 output released after reset", {15'h0, oe}, 16'h0);

    // identification, repeating
    cs_low();
    send(8'h9F);
    sb_read(8'h5A, "R5 id mfr");
    sb_read(8'h31, "R5 id dev hi");
    sb_read(8'h17, "R5 id dev lo");
    sb_read(8'h5A, "R5 id repeats");
    cs_high();
    check(oe === 1'b0, "R2 released after deselect", {15'h0, oe}, 16'h0);

    cs_low();
    send(8'h05);
    sb_read(8'h00, "R3 status idle");
    sb_read(8'h00, "R3 status repeats");
    cs_high();

    op_frame(8'h06);
    status_expect(8'h02, "R4 latch set");
    op_frame(8'h04);
    status_expect(8'h00, "R4 latch cleared");

    // erase without latch does nothing
    op_frame(8'h60);
    status_expect(8'h00, "R9 erase needs latch");

    // chip erase through the alternate opcode
    op_frame(8'h06);
    op_frame(8'hC7);
    cs_low();
    send(8'h05);
    sb_read(8'h01, "R9 busy during erase, R11 latch cleared");
    sb_read(8'h01, "R3 status repeats while busy");
    cs_high();
    op_frame(8'h06);
    cs_low();
    send(8'h03);
    send_addr(24'h0);
    send(8'h00);
    send(8'h00);
    cs_high();
    check(oe_seen == 1'b0, "R11 read ignored while busy", {15'h0, oe_seen}, 16'h0);
    wait_ready();
    status_expect(8'h00, "R11 latch request ignored while busy");

    cs_low();
    send(8'h03);
    send_addr(24'h000010);
    sb_read(8'hFF, "R9 erased byte");
    sb_read(8'hFF, "R9 erased next byte");
    cs_high();

    // page program wrapping inside page 0xF0
    op_frame(8'h06);
    cs_low();
    send(8'h02);
    send_addr(24'h0000FE);
    send(8'hA5);
    send(8'h3C);
    send(8'h0F);
    cs_high();
    status_expect(8'h01, "R8 program busy");
    wait_ready();
    cs_low();
    send(8'h03);
    send_addr(24'h0000FE);
    sb_read(8'hA5, "R8 programmed byte");
    sb_read(8'h3C, "R6 increment");
    sb_read(8'hFF, "R6 wrap to address 0");
    cs_high();
    cs_low();
    send(8'h03);
    send_addr(24'h7700F0);
    sb_read(8'h0F, "R8 wrap inside page, R6 upper address ignored");
    sb_read(8'hFF, "R6 next byte");
    cs_high();

    // fast read in mode 3
    mode3 = 1'b1;
    cs_low();
    send(8'h0B);
    send_addr(24'h0000FE);
    send(8'h00);
    sb_read(8'hA5, "R7 fast read after dummy, R1 mode 3");
    sb_read(8'h3C, "R7 fast read next");
    cs_high();
    status_expect(8'h00, "R1 mode 3 status");
    mode3 = 1'b0;

    // program ANDs into existing data
    op_frame(8'h06);
    cs_low();
    send(8'h02);
    send_addr(24'h0000FE);
    send(8'hF0);
    cs_high();
    wait_ready();
    cs_low();
    send(8'h03);
    send_addr(24'h0000FE);
    sb_read(8'hA0, "R8 AND into array");
    cs_high();

    // program without latch
    cs_low();
    send(8'h02);
    send_addr(24'h0000FF);
    send(8'h00);
    cs_high();
    status_expect(8'h00, "R8 no program without latch");
    cs_low();
    send(8'h03);
    send_addr(24'h0000FF);
    sb_read(8'h3C, "R8 array unchanged");
    cs_high();

    // manufacturer/device pair in both orders
    cs_low();
    send(8'h90);
    send_addr(24'h0);
    sb_read(8'h5A, "R14 mfr first");
    sb_read(8'h17, "R14 dev second");
    sb_read(8'h5A, "R14 alternates");
    cs_high();
    cs_low();
    send(8'hEF);
    send_addr(24'h1);
    sb_read(8'h17, "R14 dev first");
    sb_read(8'h5A, "R14 mfr second");
    cs_high();

    // unknown opcode: standby for the rest of the frame
    cs_low();
    send(8'hFF);
    send(8'h05);
    send(8'h00);
    cs_high();
    check(oe_seen == 1'b0, "R12 standby drives nothing", {15'h0, oe_seen}, 16'h0);
    status_expect(8'h00, "R12 next frame decodes");

    // deep power-down
    op_frame(8'hB9);
    cs_low();
    send(8'h05);
    send(8'h00);
    cs_high();
    check(oe_seen == 1'b0, "R13 status ignored in power-down", {15'h0, oe_seen}, 16'h0);
    op_frame(8'h06);
    cs_low();
    send(8'hAB);
    send(8'h00);
    send(8'h00);
    send(8'h00);
    sb_read(8'h17, "R13 release returns device byte");
    cs_high();
    status_expect(8'h00, "R13 awake, latch request was ignored");

    // status write
    op_frame(8'h06);
    cs_low();
    send(8'h01);
    send(8'hAB);
    cs_high();
    status_expect(8'hA9, "R10 user bits written, busy");
    wait_ready();
    status_expect(8'hA8, "R10 user bits kept");
    cs_low();
    send(8'h01);
    send(8'h00);
    cs_high();
    status_expect(8'hA8, "R10 status write needs latch");

    finished = 1'b1;
    wait_clk(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule